// File: doc/BRIEF.md
# Variable-Top PWM Timer

An 8-bit up-counter with a selectable clock divider and two compare registers. In normal mode it counts through the full 8-bit range. Compare A can raise a match pulse, can clear the counter and can drive an action on a waveform pin. In PWM mode compare B sets the top of the count, so it sets the PWM period. Compare A sets the duty of the waveform pin.

The divider takes one of two enable streams: a slow system enable, or a fast peripheral enable that runs sixteen times as often. Each stream feeds its own binary divider chain. A 4-bit select code picks one tap. The surrounding register logic drives the write strobes, the mode bits and the force strobe. It receives the counter value and two one-cycle event pulses, which it can turn into interrupt flags.

Top module: `vtop_pwm_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the waveform pin is 0, both event pulses are 0, and compare A, its buffer and compare B are 0.
- R2: Select code 0 stops counting. Codes 1 to 4 take a tick on every 1st, 2nd, 4th or 8th fast enable. Codes 5 to 15 take a tick on every 2^(code-5)-th slow enable, from 1 up to 1024.
- R3: A prescaler-clear strobe zeroes both divider chains and suppresses the tick in that cycle. With a divide ratio of N, the first tick after the clear comes on the N-th enable.
- R4: In normal mode each tick adds one to the count. The count wraps from 0xFF to 0x00, and the overflow pulse is raised in that cycle.
- R5: A tick that moves the count onto the active compare-A value raises the compare pulse. In normal mode, with clear-on-match set, the tick taken while the count equals compare A loads 0 instead of count+1.
- R6: In normal mode a compare hit applies the 2-bit pin action: 00 holds the pin, 01 toggles it, 10 drives it low and 11 drives it high.
- R7: A force strobe in normal mode applies the pin action without raising the compare pulse. In PWM mode the force strobe has no effect.
- R8: In PWM mode the count runs from 0 up to compare B and then returns to 0, with an overflow pulse at the return. If the count is above compare B, it runs to 0xFF and wraps.
- R9: In PWM mode, with a nonzero pin action, the pin is updated on every counting tick. It is 1 while the new count is below the active compare A and 0 otherwise. Compare A = 0 therefore gives a constant low pin.
- R10: In PWM mode a write to compare A goes to a buffer, and the buffer becomes active only on the tick that returns the count to 0. In normal mode a write takes effect in the next cycle.
- R11: A counter write loads the written value in the next cycle and takes precedence over a tick in that cycle. That cycle raises no compare pulse and no overflow pulse. Counting resumes from the written value on the next tick.
- R12: The compare and overflow pulses last one cycle and appear together with the count update that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_ce | input | 1 | Slow system clock enable |
| fast_ce | input | 1 | Fast peripheral clock enable (16x) |
| clk_sel | input | 4 | Divider tap select, 0 = stopped |
| psc_clr | input | 1 | Prescaler clear strobe |
| pwm_mode | input | 1 | 1 = PWM mode, 0 = normal mode |
| clr_on_match | input | 1 | Normal mode: clear count on compare A |
| pin_act | input | 2 | Waveform pin action code |
| force_cmp | input | 1 | Force-compare strobe |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmpa_wr | input | 1 | Compare A write strobe |
| cmpa_wdata | input | 8 | Compare A write value |
| cmpb_wr | input | 1 | Compare B write strobe |
| cmpb_wdata | input | 8 | Compare B write value |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform pin |
| cmpa_hit | output | 1 | Compare A event pulse |
| ovf_hit | output | 1 | Overflow / top-wrap event pulse |

## Verification
The case hardest to reach is the slowest divider tap. At a 1024 slow-enable ratio, with one slow enable every sixteen cycles, a single tick arrives only after more than sixteen thousand cycles. The stimulus clears the prescaler, holds that tap for the whole window and checks that exactly one tick was taken.

The compare-A buffer also needs care, since a write made in the middle of a PWM period may only change the pin after the next return to 0. The stimulus writes new duty values in the middle of a period. These include 0 and a value above the top. A behavioural model compares the count, the pin and both pulses every cycle. The count is also pushed above a lowered top, to cover the path through 0xFF.

// File: rtl/vtp_pkg.sv
// Shared types for the variable-top PWM timer.
// Assumes: pin action codes are fixed by the register map.
package vtp_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } pin_act_e;

endpackage

// File: rtl/vtp_prescaler.sv
// Two binary divider chains, one on the slow enable and one on the fast
// enable. Select code 0 stops the timer. Codes 1..FAST_BITS+1 pick a fast
// tap and the next SLOW_BITS+1 codes pick a slow tap.
// Assumes: the enables are single-cycle pulses in the clk domain.
module vtp_prescaler #(
    parameter int SEL_W     = 4,
    parameter int SLOW_BITS = 10,
    parameter int FAST_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_ce,
    input  logic             fast_ce,
    input  logic             psc_clr,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);
    localparam int FAST_TAPS = FAST_BITS + 1;
    localparam int SLOW_TAPS = SLOW_BITS + 1;
    localparam int FAST_LO   = 1;
    localparam int SLOW_LO   = FAST_LO + FAST_TAPS;

    logic [SLOW_BITS-1:0] slow_q;
    logic [FAST_BITS-1:0] fast_q;
    logic [SLOW_TAPS-1:0] slow_tap;
    logic [FAST_TAPS-1:0] fast_tap;

    // Advance each chain on its enable; a clear strobe restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n || psc_clr) begin
            slow_q <= '0;
            fast_q <= '0;
        end else begin
            if (sys_ce)  slow_q <= slow_q + 1'b1;
            if (fast_ce) fast_q <= fast_q + 1'b1;
        end
    end

    // A tap of ratio 2^k fires when the low k bits of its chain are all ones.
    for (genvar k = 0; k < SLOW_TAPS; k++) begin : g_slow
        if (k == 0) begin : g_base
            assign slow_tap[k] = sys_ce;
        end else begin : g_div
            assign slow_tap[k] = sys_ce && (&slow_q[k-1:0]);
        end
    end

    for (genvar k = 0; k < FAST_TAPS; k++) begin : g_fast
        if (k == 0) begin : g_base
            assign fast_tap[k] = fast_ce;
        end else begin : g_div
            assign fast_tap[k] = fast_ce && (&fast_q[k-1:0]);
        end
    end

    // Route the selected tap; no tick in a clear cycle.
    always_comb begin
        tick = 1'b0;
        if (!psc_clr) begin
            for (int k = 0; k < FAST_TAPS; k++)
                if (clk_sel == SEL_W'(FAST_LO + k)) tick = fast_tap[k];
            for (int k = 0; k < SLOW_TAPS; k++)
                if (clk_sel == SEL_W'(SLOW_LO + k)) tick = slow_tap[k];
        end
    end

endmodule

// File: rtl/vtp_count_core.sv
// Counter, compare registers and event pulses. It computes the next count
// for both modes and the compare-A value that applies to that next count.
// In PWM mode the buffered compare A is loaded on a return to zero.
// Assumes: a counter write takes precedence over a tick.
module vtp_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm_mode,
    input  logic         clr_on_match,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmpa_wr,
    input  logic [W-1:0] cmpa_wdata,
    input  logic         cmpb_wr,
    input  logic [W-1:0] cmpb_wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] cnt_next,
    output logic [W-1:0] a_eff,
    output logic         step,
    output logic         hit_now,
    output logic         cmpa_hit,
    output logic         ovf_hit
);
    logic [W-1:0] a_q;
    logic [W-1:0] a_buf_q;
    logic [W-1:0] b_q;
    logic         at_max;
    logic         wrap;

    // Decide the next count, the wrap condition and the compare value in force.
    always_comb begin
        step   = tick && !cnt_wr;
        at_max = (count == {W{1'b1}});
        wrap   = pwm_mode ? (at_max || count == b_q) : at_max;
        a_eff  = (pwm_mode && wrap) ? a_buf_q : a_q;
        if (pwm_mode)
            cnt_next = wrap ? '0 : count + 1'b1;
        else if (clr_on_match && count == a_q)
            cnt_next = '0;
        else
            cnt_next = count + 1'b1;
        hit_now = step && (cnt_next == a_eff);
    end

    // Counter register: a write wins, otherwise advance on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= cnt_wdata;
        else if (step)   count <= cnt_next;
    end

    // One-cycle event pulses aligned with the count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa_hit <= 1'b0;
            ovf_hit  <= 1'b0;
        end else begin
            cmpa_hit <= hit_now;
            ovf_hit  <= step && wrap;
        end
    end

    // Compare registers; in PWM mode compare A goes live only on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            a_buf_q <= '0;
            b_q     <= '0;
        end else begin
            if (cmpb_wr) b_q <= cmpb_wdata;
            if (cmpa_wr) a_buf_q <= cmpa_wdata;
            if (pwm_mode) begin
                if (step && wrap) a_q <= a_buf_q;
            end else begin
                a_q <= cmpa_wr ? cmpa_wdata : a_buf_q;
            end
        end
    end

endmodule

// File: rtl/vtp_wave.sv
// Waveform pin. In PWM mode the pin level comes from the next count and
// the compare value in force. In normal mode a hit or a force strobe
// applies the configured pin action.
// Assumes: hit_now and step come from the counter core in the same cycle.
module vtp_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm_mode,
    input  logic [1:0]   pin_act,
    input  logic         force_cmp,
    input  logic         step,
    input  logic         hit_now,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] a_eff,
    output logic         wave_out
);
    import vtp_pkg::*;

    pin_act_e act;
    logic     pin_d;

    // Choose the next pin level for the active mode.
    always_comb begin
        act   = pin_act_e'(pin_act);
        pin_d = wave_out;
        if (pwm_mode) begin
            if (step && act != ACT_HOLD) pin_d = (cnt_next < a_eff);
        end else if (hit_now || force_cmp) begin
            case (act)
                ACT_TOGGLE: pin_d = !wave_out;
                ACT_CLEAR:  pin_d = 1'b0;
                ACT_SET:    pin_d = 1'b1;
                default:    pin_d = wave_out;
            endcase
        end
    end

    // Pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_out <= 1'b0;
        else        wave_out <= pin_d;
    end

endmodule

// File: rtl/vtop_pwm_timer.sv
// Top of the variable-top PWM timer: prescaler, counter core and pin stage.
// Assumes: all strobes and enables are synchronous to clk.
module vtop_pwm_timer #(
    parameter int CNT_W     = 8,
    parameter int SEL_W     = 4,
    parameter int SLOW_BITS = 10,
    parameter int FAST_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_ce,
    input  logic             fast_ce,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             psc_clr,
    input  logic             pwm_mode,
    input  logic             clr_on_match,
    input  logic [1:0]       pin_act,
    input  logic             force_cmp,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmpa_wr,
    input  logic [CNT_W-1:0] cmpa_wdata,
    input  logic             cmpb_wr,
    input  logic [CNT_W-1:0] cmpb_wdata,
    output logic [CNT_W-1:0] count,
    output logic             wave_out,
    output logic             cmpa_hit,
    output logic             ovf_hit
);
    logic             tick;
    logic             step;
    logic             hit_now;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] a_eff;

    vtp_prescaler #(
        .SEL_W(SEL_W), .SLOW_BITS(SLOW_BITS), .FAST_BITS(FAST_BITS)
    ) u_psc (
        .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .fast_ce(fast_ce),
        .psc_clr(psc_clr), .clk_sel(clk_sel), .tick(tick)
    );

    vtp_count_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_mode(pwm_mode),
        .clr_on_match(clr_on_match), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata), .cmpb_wr(cmpb_wr),
        .cmpb_wdata(cmpb_wdata), .count(count), .cnt_next(cnt_next),
        .a_eff(a_eff), .step(step), .hit_now(hit_now),
        .cmpa_hit(cmpa_hit), .ovf_hit(ovf_hit)
    );

    vtp_wave #(.W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .pin_act(pin_act),
        .force_cmp(force_cmp), .step(step), .hit_now(hit_now),
        .cnt_next(cnt_next), .a_eff(a_eff), .wave_out(wave_out)
    );

endmodule

// File: rtl/vtp_timer_chk.sv
// Property checker for the timer, attached to the top module by bind.
module vtp_timer_chk #(
    parameter int W     = 8,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [W-1:0]     cnt_wdata,
    input logic [SEL_W-1:0] clk_sel,
    input logic             pwm_mode,
    input logic [1:0]       pin_act,
    input logic [W-1:0]     count,
    input logic             wave_out,
    input logic             cmpa_hit,
    input logic             ovf_hit,
    input logic             step,
    input logic [W-1:0]     a_eff
);
    logic past_ok;

    // Marks cycles whose previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst_n && !past_ok |-> count == '0 && !wave_out && !cmpa_hit && !ovf_hit);

    a_r11_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cnt_wr) |-> count == $past(cnt_wdata) && !cmpa_hit && !ovf_hit);

    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(clk_sel == '0 && !cnt_wr) |-> count == $past(count) && !cmpa_hit && !ovf_hit);

    a_r4_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |-> count == '0);

    a_r5_hit_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && cmpa_hit |-> $past(step));

    a_r9_pwm_level: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(pwm_mode && pin_act != 2'b00 && step) |-> wave_out == (count < $past(a_eff)));

endmodule

bind vtop_pwm_timer vtp_timer_chk #(.W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .clk_sel(clk_sel), .pwm_mode(pwm_mode), .pin_act(pin_act),
    .count(count), .wave_out(wave_out), .cmpa_hit(cmpa_hit),
    .ovf_hit(ovf_hit), .step(step), .a_eff(a_eff)
);

// File: tb/vtop_pwm_timer_test.sv
module vtop_pwm_timer_test;
    logic       clk = 1'b0;
    logic       rst_n, sys_ce, fast_ce, psc_clr, pwm_mode, clr_on_match;
    logic       force_cmp, cnt_wr, cmpa_wr, cmpb_wr;
    logic [3:0] clk_sel;
    logic [1:0] pin_act;
    logic [7:0] cnt_wdata, cmpa_wdata, cmpb_wdata, count;
    logic       wave_out, cmpa_hit, ovf_hit;

    always #5 clk = ~clk;

    vtop_pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .fast_ce(fast_ce),
        .clk_sel(clk_sel), .psc_clr(psc_clr), .pwm_mode(pwm_mode),
        .clr_on_match(clr_on_match), .pin_act(pin_act), .force_cmp(force_cmp),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmpa_wr(cmpa_wr),
        .cmpa_wdata(cmpa_wdata), .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
        .count(count), .wave_out(wave_out), .cmpa_hit(cmpa_hit), .ovf_hit(ovf_hit)
    );

    int    checks = 0, fails = 0, cycles = 0, ph = 0;
    string phase = "R1";
    bit    done = 0;

    // reference model state
    int m_cnt, m_a, m_buf, m_b, m_sys, m_fast, sel, dv, aeff, nxt;
    bit m_pin, m_hit, m_ovf, tk, adv, wrapped;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (phase %s): actual %0d expected %0d", tag, phase, act, exp);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_cnt = 0; m_a = 0; m_buf = 0; m_b = 0; m_sys = 0; m_fast = 0;
            m_pin = 0; m_hit = 0; m_ovf = 0;
        end else begin
            tk = 0; sel = int'(clk_sel);
            if (psc_clr) begin
                m_sys = 0; m_fast = 0;
            end else begin
                if (sys_ce)  m_sys  = (m_sys + 1) % 1024;
                if (fast_ce) m_fast = (m_fast + 1) % 8;
                if (sel >= 1 && sel <= 4) begin
                    dv = 1 << (sel - 1); tk = fast_ce && (m_fast % dv == 0);
                end else if (sel >= 5) begin
                    dv = 1 << (sel - 5); tk = sys_ce && (m_sys % dv == 0);
                end
            end
            m_hit = 0; m_ovf = 0; wrapped = 0;
            aeff = m_a; nxt = m_cnt; adv = tk && !cnt_wr;
            if (adv) begin
                if (pwm_mode) begin
                    if (m_cnt == m_b || m_cnt == 255) begin
                        nxt = 0; wrapped = 1; aeff = m_buf;
                    end else nxt = m_cnt + 1;
                end else begin
                    if (clr_on_match && m_cnt == m_a) nxt = 0;
                    else nxt = (m_cnt + 1) % 256;
                    wrapped = (m_cnt == 255);
                end
                m_ovf = wrapped;
                m_hit = (nxt == aeff);
                if (pwm_mode && pin_act != 2'b00) m_pin = (nxt < aeff);
            end
            if (!pwm_mode && (m_hit || force_cmp)) begin
                case (pin_act)
                    2'b01: m_pin = !m_pin;
                    2'b10: m_pin = 0;
                    2'b11: m_pin = 1;
                    default: ;
                endcase
            end
            m_cnt = cnt_wr ? int'(cnt_wdata) : nxt;
            if (pwm_mode) begin
                if (adv && wrapped) m_a = m_buf;
                if (cmpa_wr) m_buf = int'(cmpa_wdata);
            end else begin
                if (cmpa_wr) m_buf = int'(cmpa_wdata);
                m_a = m_buf;
            end
            if (cmpb_wr) m_b = int'(cmpb_wdata);
        end
    endtask

    // Model update at each edge, comparison shortly after it.
    always @(posedge clk) begin
        cycles++;
        model_step();
        #2;
        if (!done) begin
            chk(pwm_mode ? "R8 count" : "R4 count", int'(count), m_cnt);
            chk(pwm_mode ? "R9 pin" : "R6 pin", int'(wave_out), int'(m_pin));
            chk("R5 R12 compare pulse", int'(cmpa_hit), int'(m_hit));
            chk("R4 R12 overflow pulse", int'(ovf_hit), int'(m_ovf));
        end
        if (cycles > 100000 && !done) begin
            fails++; checks++; done = 1;
            $display("FAIL watchdog (phase %s): actual %0d expected %0d", phase, cycles, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Advance n cycles; strobes last one cycle, slow enable every 16 cycles.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_wr = 0; cmpa_wr = 0; cmpb_wr = 0; psc_clr = 0; force_cmp = 0;
            sys_ce = (ph == 15);
            ph = (ph + 1) % 16;
        end
    endtask

    int snap, peak;

    initial begin
        rst_n = 0; sys_ce = 0; fast_ce = 0; clk_sel = 0; psc_clr = 0;
        pwm_mode = 0; clr_on_match = 0; pin_act = 0; force_cmp = 0;
        cnt_wr = 0; cmpa_wr = 0; cmpb_wr = 0;
        cnt_wdata = 0; cmpa_wdata = 0; cmpb_wdata = 0;
        run(3);
        rst_n = 1;
        run(1);
        chk("R1 count", int'(count), 0);
        chk("R1 pin", int'(wave_out), 0);
        chk("R1 pulses", int'(cmpa_hit) + int'(ovf_hit), 0);

        // R4: full-range counting on the fast /1 tap.
        phase = "R4"; cmpa_wdata = 8'd200; cmpa_wr = 1; run(1);
        fast_ce = 1; clk_sel = 4'd1; pin_act = 2'b01;
        run(300);

        // R2: code 0 stops the timer.
        phase = "R2"; clk_sel = 4'd0; run(1);
        snap = int'(count); run(30);
        chk("R2 stopped count", int'(count), snap);
        clk_sel = 4'd4; run(40);
        clk_sel = 4'd7; run(130);

        // R3: clear, then the slowest tap gives one tick in 1024 slow enables.
        phase = "R3"; clk_sel = 4'd6; run(37); psc_clr = 1; run(80);
        clk_sel = 4'd15; psc_clr = 1; run(1);
        snap = int'(count); run(16 * 1024 + 20);
        chk("R3 R2 slowest tap one tick", (int'(count) - snap + 256) % 256, 1);

        // R11: counter write precedence and resume.
        phase = "R11"; clk_sel = 4'd1;
        cnt_wdata = 8'hFD; cnt_wr = 1; run(1);
        chk("R11 written value", int'(count), 8'hFD);
        chk("R11 no pulse on write", int'(cmpa_hit) + int'(ovf_hit), 0);
        run(6);
        cmpa_wdata = 8'h30; cmpa_wr = 1; run(3);
        cnt_wdata = 8'h30; cnt_wr = 1; run(1);
        chk("R11 write onto compare value gives no hit", int'(cmpa_hit), 0);
        run(1);
        chk("R11 counting resumes", int'(count), 8'h31);

        // R5/R6: clear on match with toggle action.
        phase = "R5"; clr_on_match = 1; cmpa_wdata = 8'd20; cmpa_wr = 1;
        cnt_wdata = 0; cnt_wr = 1; run(1);
        peak = 0;
        for (int i = 0; i < 120; i++) begin
            run(1);
            if (int'(count) > peak) peak = int'(count);
        end
        chk("R5 clear-on-match bounds count", peak, 20);
        phase = "R6"; pin_act = 2'b10; run(30); pin_act = 2'b11; run(30);

        // R7: force strobe in normal mode, clock stopped.
        phase = "R7"; clk_sel = 0; pin_act = 2'b10; force_cmp = 1; run(1);
        chk("R7 force clears pin", int'(wave_out), 0);
        chk("R7 force raises no hit", int'(cmpa_hit), 0);
        pin_act = 2'b11; force_cmp = 1; run(1);
        chk("R7 force sets pin", int'(wave_out), 1);
        pin_act = 2'b00; force_cmp = 1; run(1);
        chk("R7 hold action keeps pin", int'(wave_out), 1);

        // R8/R9/R10: PWM with top 9 and buffered duty updates.
        phase = "R8"; clr_on_match = 0; pwm_mode = 1; pin_act = 2'b10;
        cmpb_wdata = 8'd9; cmpb_wr = 1; cmpa_wdata = 8'd4; cmpa_wr = 1;
        cnt_wdata = 0; cnt_wr = 1; run(1);
        clk_sel = 4'd1; run(45);
        phase = "R10"; cmpa_wdata = 8'd7; cmpa_wr = 1; run(33);
        cmpa_wdata = 8'd0; cmpa_wr = 1; run(25);
        phase = "R9"; snap = 0;
        for (int i = 0; i < 20; i++) begin
            run(1);
            snap += int'(wave_out);
        end
        chk("R9 duty 0 stays low", snap, 0);
        phase = "R10"; cmpa_wdata = 8'd12; cmpa_wr = 1; run(25);
        phase = "R9"; snap = 0;
        for (int i = 0; i < 20; i++) begin
            run(1);
            snap += int'(wave_out);
        end
        chk("R9 duty above top stays high", snap, 20);

        // R7: force has no effect in PWM mode.
        phase = "R7"; clk_sel = 0; pin_act = 2'b10; run(1);
        snap = int'(wave_out); force_cmp = 1; run(1);
        chk("R7 force ignored in PWM", int'(wave_out), snap);

        // R8: count above a lowered top runs through 0xFF.
        phase = "R8"; clk_sel = 4'd2; cmpa_wdata = 8'd5; cmpa_wr = 1;
        cnt_wdata = 8'd200; cnt_wr = 1; run(140);
        pin_act = 2'b00; run(30);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule